// File: doc/BRIEF.md
# Serial Command and Subcode-Q Host Port

This block is the slave side of a three-wire link between a host controller and a disc playback signal processor. The host drives a shift clock, a latch line and one data line that is shared in both directions. While the latch is high the host shifts in a command byte. When the latch falls, the byte takes effect: its upper two fields set the spindle motor mode and the audio output mode, and its lower four bits choose a status value. The block then drives that status on the data line for as long as the latch stays low. When the latch rises, the block releases the data line.

The block also holds an 80-bit subcode-Q buffer. The buffer is loaded from a refresh strobe, but only when the error check has passed and both sync patterns were seen. A load marks the buffer as ready. The host queries the ready status. If the reply is low, the host keeps the latch low and applies 81 shift clocks. The first 80 clocks bring the buffer out, with the bit order reversed within each byte. The 81st clock clears the ready mark. The buffer is never reloaded while the latch is low.

The host pins are asynchronous to the system clock. Each host pin passes through a two-flop synchroniser, and the block detects edges on the synchronised levels. The link is plain level signalling clocked by the host, so there is no valid/ready handshake and no back-pressure. The host sets the pace by how fast it toggles the shift clock.

Top module: `subq_host_port`

## Requirements
- R1: Data bits are taken on each rising edge of the shift clock. The first bit taken is D0 and the last is D7. The last eight bits taken before the latch falls form the command, and the command takes effect on that falling edge.
- R2: Command bits D7:D6 set `motor_mode`: 00 = stopped, 01 = full acceleration, 10 = full braking, 11 = constant linear velocity control. After reset the value is 00.
- R3: Command bits D5:D4 set `audio_mode`: 00 = muted, 01 = playing, 11 = 12 dB attenuation. After reset the value is 00.
- R4: The D5:D4 code 10 is prohibited. It leaves `audio_mode` unchanged, and D7:D6 and D3:D0 of the same command still take effect.
- R5: `sdo_oe` goes high when a command is committed and stays high until the latch returns high. Once the latch is high again, `sdo_oe` is low. It is also low after reset.
- R6: While `sdo_oe` is high, `sdo` follows the live input level selected by D3:D0: 0000 = `low_rot_n`, 0001 = `pll_lock_n`, 0011 = `exp_a`, 0100 = `exp_b`.
- R7: D3:D0 codes from 0101 to 1011 set mode outputs. The codes are: 0101 = digital audio out on, 0110 = digital audio out off, 0111 = clock accuracy level 0, 1000 = clock accuracy level 1, 1001 = external I2S format, 1010 = external alternate format, 1011 = internal converter. In `dac_sel`, 0 = internal, 1 = I2S and 2 = alternate. After reset `dout_on` is 0, `acc_lvl` is 0 and `dac_sel` is 0. Codes 1100 to 1111 change none of these outputs. For every code from 0101 to 1111, `sdo` returns 1.
- R8: A cycle with `q_stb`, `q_crc_ok` and `q_sync_ok` all high loads `q_data` and sets the ready mark, provided the latch is high. Code 0010 latches a reply at commit: 0 if the ready mark is set, 1 if it is not.
- R9: While the latch is low, a qualified strobe changes neither the buffer nor the ready mark. If a qualified strobe coincides with the commit of code 0010, the reply is 1.
- R10: After a ready reply of 0, rising clock n (where n runs from 1 to 80) puts stream bit k = n-1 on `sdo`. That bit is buffer bit 8*(k/8) + 7 - (k mod 8). The 81st rising clock drives `sdo` to 1 and clears the ready mark.
- R11: A strobe with `q_crc_ok` or `q_sync_ok` low loads nothing and does not set the ready mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_lat | input | 1 | Host latch line (asynchronous) |
| host_sck | input | 1 | Host shift clock (asynchronous) |
| host_sdi | input | 1 | Data line, host-to-block direction |
| sdo | output | 1 | Data line, block-to-host value |
| sdo_oe | output | 1 | Data line drive enable |
| low_rot_n | input | 1 | Low when disc speed is under 2/3 of nominal |
| pll_lock_n | input | 1 | Low when the PLL is locked |
| exp_a | input | 1 | Expansion input A |
| exp_b | input | 1 | Expansion input B |
| q_stb | input | 1 | Subcode-Q refresh strobe |
| q_crc_ok | input | 1 | Q error check passed |
| q_sync_ok | input | 1 | Both subcode sync patterns found in position |
| q_data | input | 80 | New Q word |
| motor_mode | output | 2 | Spindle motor mode |
| audio_mode | output | 2 | Audio output mode |
| dout_on | output | 1 | Digital audio output enable |
| acc_lvl | output | 1 | Clock accuracy level |
| dac_sel | output | 2 | Converter / serial format select |

## Verification
The bench uses the default parameters: an 80-bit Q word, an 8-bit command and two synchroniser stages. With these values the bench can run a complete 81-clock readout and confirm the per-byte reversal across every byte boundary. It can also check that the counter saturates past the last clock. With two synchroniser stages the bench can hold each host pin phase for a few system clocks and land a refresh strobe exactly on the detected latch fall. Random command bytes, random input levels and random Q words are combined with directed cases: the prohibited audio code, a failed-check strobe, a strobe while the latch is low, and a strobe that coincides with the commit.

// File: rtl/subq_host_pkg.sv
package subq_host_pkg;
  typedef enum logic [1:0] {MOT_STOP = 2'b00, MOT_ACCEL = 2'b01, MOT_BRAKE = 2'b10, MOT_CLV = 2'b11} motor_e;
  typedef enum logic [1:0] {AUD_MUTE = 2'b00, AUD_PLAY = 2'b01, AUD_BAD = 2'b10, AUD_ATT12 = 2'b11} audio_e;
  typedef enum logic [1:0] {FMT_INT = 2'b00, FMT_I2S = 2'b01, FMT_ALT = 2'b10} fmt_e;

  localparam logic [3:0] SEL_ROT    = 4'd0;
  localparam logic [3:0] SEL_PLL    = 4'd1;
  localparam logic [3:0] SEL_RDY    = 4'd2;
  localparam logic [3:0] SEL_EXPA   = 4'd3;
  localparam logic [3:0] SEL_EXPB   = 4'd4;
  localparam logic [3:0] SEL_DO_ON  = 4'd5;
  localparam logic [3:0] SEL_DO_OFF = 4'd6;
  localparam logic [3:0] SEL_ACC0   = 4'd7;
  localparam logic [3:0] SEL_ACC1   = 4'd8;
  localparam logic [3:0] SEL_I2S    = 4'd9;
  localparam logic [3:0] SEL_ALT    = 4'd10;
  localparam logic [3:0] SEL_INT    = 4'd11;
endpackage

// File: rtl/subq_host_sync.sv
module subq_host_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] pipe [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/subq_host_cmd.sv
module subq_host_cmd
  import subq_host_pkg::*;
#(
  parameter int CMDW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       bit_in,
  input  logic       commit,
  output logic [3:0] pend_sel,
  output logic [3:0] sel,
  output motor_e     motor,
  output audio_e     audio,
  output logic       dout_on,
  output logic       acc_lvl,
  output fmt_e       fmt
);
  localparam int MSB = CMDW - 1;
  logic [CMDW-1:0] sr;

  assign pend_sel = sr[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (bit_stb) sr <= {bit_in, sr[MSB:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= SEL_ROT;
      motor   <= MOT_STOP;
      audio   <= AUD_MUTE;
      dout_on <= 1'b0;
      acc_lvl <= 1'b0;
      fmt     <= FMT_INT;
    end else if (commit) begin
      sel   <= sr[3:0];
      motor <= motor_e'(sr[MSB -: 2]);
      if (sr[MSB-2 -: 2] != AUD_BAD) audio <= audio_e'(sr[MSB-2 -: 2]);
      case (sr[3:0])
        SEL_DO_ON:  dout_on <= 1'b1;
        SEL_DO_OFF: dout_on <= 1'b0;
        SEL_ACC0:   acc_lvl <= 1'b0;
        SEL_ACC1:   acc_lvl <= 1'b1;
        SEL_I2S:    fmt     <= FMT_I2S;
        SEL_ALT:    fmt     <= FMT_ALT;
        SEL_INT:    fmt     <= FMT_INT;
        default: ;
      endcase
    end
  end

  // R4: prohibited audio code leaves audio mode unchanged
  assert_bad_audio_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sr[MSB-2 -: 2] == AUD_BAD) |=> $stable(audio));
  // R7: codes 1100..1111 touch no mode output
  assert_spare_codes_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sr[3:2] == 2'b11) |=> $stable({dout_on, acc_lvl, fmt}));
  // R2: motor follows the committed byte
  assert_motor_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(motor));
endmodule

// File: rtl/subq_host_qbuf.sv
module subq_host_qbuf #(
  parameter int QBITS = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_hi,
  input  logic             commit_rdy,
  input  logic             commit_other,
  input  logic             sck_rise,
  input  logic             ld_stb,
  input  logic             crc_ok,
  input  logic             sync_ok,
  input  logic [QBITS-1:0] ld_data,
  output logic             rdy_reply,
  output logic             q_phase,
  output logic             q_done,
  output logic             q_bit
);
  localparam int CNTW = $clog2(QBITS + 2);
  localparam logic [CNTW-1:0] LAST = CNTW'(QBITS);

  logic [QBITS-1:0] qbuf;
  logic             ready;
  logic             rd_en;
  logic [CNTW-1:0]  cnt;
  logic [CNTW-1:0]  idx;
  logic [CNTW-1:0]  pos;
  logic             qual;

  assign qual = ld_stb & crc_ok & sync_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qbuf <= '0;
    else if (lat_hi && qual) qbuf <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready     <= 1'b0;
      rd_en     <= 1'b0;
      cnt       <= '0;
      rdy_reply <= 1'b1;
    end else begin
      if (lat_hi) begin
        rd_en <= 1'b0;
        if (qual) ready <= 1'b1;
      end else if (commit_rdy) begin
        rdy_reply <= ~(ready & ~qual);
        rd_en     <= ready & ~qual;
        cnt       <= '0;
      end else if (commit_other) begin
        rd_en <= 1'b0;
      end else if (rd_en && sck_rise && cnt <= LAST) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) ready <= 1'b0;
      end
    end
  end

  assign idx     = cnt - 1'b1;
  assign pos     = {idx[CNTW-1:3], ~idx[2:0]};
  assign q_bit   = qbuf[pos];
  assign q_phase = rd_en && cnt != '0 && cnt <= LAST;
  assign q_done  = rd_en && cnt > LAST;

  // R9: buffer frozen while latch is low
  assert_buf_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_hi |=> $stable(qbuf));
  // R10: closing clock clears the ready mark
  assert_ready_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_hi && rd_en && sck_rise && cnt == LAST && !commit_rdy && !commit_other) |=> !ready);
  // R10: counter never runs past the closing clock
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST + 1'b1);
  // R11: unqualified strobe never sets the mark
  assert_no_load_unqual_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !qual) |=> !ready);
endmodule

// File: rtl/subq_host_port.sv
module subq_host_port
  import subq_host_pkg::*;
#(
  parameter int QBITS       = 80,
  parameter int CMDW        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_lat,
  input  logic             host_sck,
  input  logic             host_sdi,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic             low_rot_n,
  input  logic             pll_lock_n,
  input  logic             exp_a,
  input  logic             exp_b,
  input  logic             q_stb,
  input  logic             q_crc_ok,
  input  logic             q_sync_ok,
  input  logic [QBITS-1:0] q_data,
  output logic [1:0]       motor_mode,
  output logic [1:0]       audio_mode,
  output logic             dout_on,
  output logic             acc_lvl,
  output logic [1:0]       dac_sel
);
  logic [2:0] s_lvl, s_rise, s_fall;
  logic       lat_hi, commit, sck_rise, sdi_s;
  logic [3:0] pend_sel, sel;
  motor_e     motor;
  audio_e     audio;
  fmt_e       fmt;
  logic       rdy_reply, q_phase, q_done, q_bit;
  logic       rd_active;
  logic       status_bit;

  subq_host_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({host_lat, host_sck, host_sdi}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall));

  assign lat_hi   = s_lvl[2];
  assign commit   = s_fall[2];
  assign sck_rise = s_rise[1];
  assign sdi_s    = s_lvl[0];

  subq_host_cmd #(.CMDW(CMDW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .bit_stb(sck_rise), .bit_in(sdi_s), .commit(commit),
    .pend_sel(pend_sel), .sel(sel), .motor(motor), .audio(audio),
    .dout_on(dout_on), .acc_lvl(acc_lvl), .fmt(fmt));

  subq_host_qbuf #(.QBITS(QBITS)) u_qbuf (
    .clk(clk), .rst_n(rst_n), .lat_hi(lat_hi),
    .commit_rdy(commit && pend_sel == SEL_RDY),
    .commit_other(commit && pend_sel != SEL_RDY),
    .sck_rise(sck_rise), .ld_stb(q_stb), .crc_ok(q_crc_ok), .sync_ok(q_sync_ok),
    .ld_data(q_data), .rdy_reply(rdy_reply), .q_phase(q_phase), .q_done(q_done),
    .q_bit(q_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_active <= 1'b0;
    else if (lat_hi) rd_active <= 1'b0;
    else if (commit) rd_active <= 1'b1;
  end

  always_comb begin
    case (sel)
      SEL_ROT:  status_bit = low_rot_n;
      SEL_PLL:  status_bit = pll_lock_n;
      SEL_RDY:  status_bit = rdy_reply;
      SEL_EXPA: status_bit = exp_a;
      SEL_EXPB: status_bit = exp_b;
      default:  status_bit = 1'b1;
    endcase
  end

  assign sdo        = q_phase ? q_bit : (q_done ? 1'b1 : status_bit);
  assign sdo_oe     = rd_active;
  assign motor_mode = motor;
  assign audio_mode = audio;
  assign dac_sel    = fmt;

  // R5: data line released once latch is back high
  assert_release_on_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_hi && $past(lat_hi)) |-> !sdo_oe);
  // R5: drive begins at the commit
  assert_drive_after_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> sdo_oe);
endmodule

// File: tb/subq_host_port_test.sv
`timescale 1ns/1ps
module subq_host_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_lat = 1'b1, host_sck = 1'b1, host_sdi = 1'b0;
  logic low_rot_n = 1'b1, pll_lock_n = 1'b1, exp_a = 1'b0, exp_b = 1'b0;
  logic q_stb = 1'b0, q_crc_ok = 1'b0, q_sync_ok = 1'b0;
  logic [79:0] q_data = '0;
  logic sdo, sdo_oe, dout_on, acc_lvl;
  logic [1:0] motor_mode, audio_mode, dac_sel;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [1:0] e_mot = 0, e_aud = 0, e_fmt = 0;
  logic e_do = 0, e_acc = 0;
  logic [79:0] qa, qb;

  always #2 clk = ~clk;

  subq_host_port uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(logic [7:0] b);
    host_lat = 1'b1;
    for (int i = 0; i < 8; i++) begin
      host_sdi = b[i];
      host_sck = 1'b0; wclk(4);
      host_sck = 1'b1; wclk(4);
    end
    host_lat = 1'b0; wclk(8);
  endtask

  task automatic release_lat();
    host_lat = 1'b1; wclk(8);
  endtask

  task automatic pulse_sck();
    host_sck = 1'b0; wclk(4);
    host_sck = 1'b1; wclk(6);
  endtask

  task automatic strobe(logic [79:0] d, logic crc, logic syn);
    q_data = d; q_crc_ok = crc; q_sync_ok = syn; q_stb = 1'b1;
    wclk(1);
    q_stb = 1'b0; q_crc_ok = 1'b0; q_sync_ok = 1'b0;
    wclk(2);
  endtask

  function automatic logic stream_bit(logic [79:0] d, int k);
    return d[8*(k/8) + 7 - (k%8)];
  endfunction

  function automatic logic exp_reply(logic [3:0] s);
    case (s)
      4'd0: return low_rot_n;
      4'd1: return pll_lock_n;
      4'd3: return exp_a;
      4'd4: return exp_b;
      default: return 1'b1;
    endcase
  endfunction

  task automatic model(logic [7:0] b);
    e_mot = b[7:6];
    if (b[5:4] != 2'b10) e_aud = b[5:4];
    case (b[3:0])
      4'd5: e_do = 1; 4'd6: e_do = 0; 4'd7: e_acc = 0; 4'd8: e_acc = 1;
      4'd9: e_fmt = 1; 4'd10: e_fmt = 2; 4'd11: e_fmt = 0;
      default: ;
    endcase
  endtask

  task automatic chk_modes(string tag);
    chk({tag, " R2 motor"}, motor_mode, e_mot);
    chk({tag, " R3 audio"}, audio_mode, e_aud);
    chk({tag, " R7 dout"}, dout_on, e_do);
    chk({tag, " R7 acc"}, acc_lvl, e_acc);
    chk({tag, " R7 fmt"}, dac_sel, e_fmt);
  endtask

  task automatic read_q(logic [79:0] d);
    for (int n = 1; n <= 80; n++) begin
      pulse_sck();
      chk($sformatf("R10 q bit %0d", n - 1), sdo, stream_bit(d, n - 1));
    end
    pulse_sck();
    chk("R10 after clock 81", sdo, 1);
  endtask

  initial begin
    wclk(3); rst_n = 1'b1; wclk(4);
    // reset state
    chk_modes("reset");
    chk("R5 reset oe", sdo_oe, 0);

    // R1/R2/R6: PLL status, CLV motor
    pll_lock_n = 1'b0;
    send_cmd(8'hC1); model(8'hC1);
    chk("R5 oe low latch", sdo_oe, 1);
    chk("R6 pll reply", sdo, 0);
    pll_lock_n = 1'b1; wclk(2);
    chk("R6 pll live", sdo, 1);
    chk_modes("cmd C1");
    release_lat();
    chk("R5 oe released", sdo_oe, 0);

    // R3 then R4 prohibited audio
    send_cmd(8'h33); model(8'h33); release_lat(); chk_modes("att");
    send_cmd(8'h60); model(8'h60); release_lat(); chk_modes("R4 prohibited");
    chk("R4 audio kept", audio_mode, 2'b11);

    // R7 mode codes and spare code
    send_cmd(8'h15); model(8'h15); chk("R7 reply", sdo, 1); release_lat();
    send_cmd(8'h18); model(8'h18); release_lat();
    send_cmd(8'h1A); model(8'h1A); release_lat(); chk_modes("R7 set");
    send_cmd(8'h1E); model(8'h1E); chk("R7 spare reply", sdo, 1); release_lat();
    chk_modes("R7 spare");

    // R8 empty: not ready, clocks stay high
    send_cmd(8'h12); chk("R8 empty reply", sdo, 1);
    pulse_sck(); chk("R8 empty clocked", sdo, 1);
    release_lat();

    // R11 failed check
    qa = {$urandom(7), $urandom, $urandom};
    strobe(qa, 1'b0, 1'b1);
    strobe(qa, 1'b1, 1'b0);
    send_cmd(8'h12); chk("R11 no load reply", sdo, 1); release_lat();

    // R9 strobe while latch low
    send_cmd(8'h10);
    strobe(qa, 1'b1, 1'b1);
    release_lat();
    send_cmd(8'h12); chk("R9 blocked while low", sdo, 1); release_lat();

    // R9 strobe coinciding with commit (fall detected 3 cycles after pin)
    qb = {$urandom, $urandom, $urandom};
    host_lat = 1'b1;
    for (int i = 0; i < 8; i++) begin
      host_sdi = i == 1; host_sck = 1'b0; wclk(4); host_sck = 1'b1; wclk(4);
    end
    q_data = qb; q_crc_ok = 1'b1; q_sync_ok = 1'b1; q_stb = 1'b1;
    host_lat = 1'b0; wclk(5);
    q_stb = 1'b0; q_crc_ok = 1'b0; q_sync_ok = 1'b0; wclk(4);
    chk("R9 coincident reply", sdo, 1);
    release_lat();

    // R8 ready then R10 readout
    send_cmd(8'h12); chk("R8 ready reply", sdo, 0);
    read_q(qb);
    release_lat();
    send_cmd(8'h12); chk("R10 mark cleared", sdo, 1); release_lat();

    // second word with R8 load then read
    strobe(qa, 1'b1, 1'b1);
    send_cmd(8'h02); chk("R8 reply 2", sdo, 0);
    read_q(qa); release_lat();

    // random commands
    for (int it = 0; it < 40; it++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (b[3:0] == 4'd2) b[3:0] = 4'd1;
      low_rot_n = 1'($urandom); pll_lock_n = 1'($urandom);
      exp_a = 1'($urandom); exp_b = 1'($urandom);
      send_cmd(b); model(b);
      chk($sformatf("R1 R6 reply %02h", b), sdo, exp_reply(b[3:0]));
      chk_modes("rand");
      release_lat();
      chk("R5 rand release", sdo_oe, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule